// File: doc/BRIEF.md
# Brain-Float Immediate to Double Widener

This block serves the floating-point load-immediate path of an instruction pipeline. It takes a 32-bit instruction word and a valid strobe. When the word carries the load-immediate opcodes, the block rebuilds the 16-bit brain-float constant packed in the word. It widens that constant to a 32-bit single by placing sixteen zero bits below it, then converts the single to a 64-bit double-precision value. The double is ready to be written to a floating-point register.

One cycle after the word is accepted, the block presents the double, the destination register index taken from the word and an output strobe. Words that do not match the opcodes produce no strobe, and the registered outputs keep their last values. The conversion covers signed zero, subnormal inputs (which are renormalised), normal values, infinities and NaNs.

Top module: `bf16_imm_expander`

## Requirements
- R1: The 16-bit immediate is `{instrWord[0], instrWord[20:6]}`. Bit 15 of the immediate is the sign, bits 14:7 are the exponent and bits 6:0 are the top fraction bits. The single is this immediate followed by sixteen zero bits.
- R2: `resValid` is 1 exactly one cycle after a cycle in which `instrValid` is 1, `instrWord[31:26]` equals `MAJOR_OP` (default 19) and `instrWord[5:1]` equals `EXT_OP` (default 22).
- R3: A cycle with `instrValid` low, or with either opcode field different from its constant, gives `resValid` low one cycle later, and `resData` and `resDest` keep their previous values.
- R4: `resDest` equals `instrWord[25:21]` of the accepted word.
- R5: An immediate with zero exponent and zero fraction yields a double zero with the same sign: `resData[62:0]` is 0 and `resData[63]` is the immediate sign.
- R6: For a normal immediate (exponent 1 to 254), the double exponent is the single exponent plus 896. The 23-bit single fraction fills the top of the 52-bit double fraction and is followed by 29 zeros.
- R7: For a subnormal immediate (zero exponent, non-zero fraction), the fraction is shifted left until its leading one drops out. The double exponent is 896 minus the number of leading zeros in the 23-bit fraction, and the remaining bits fill the top of the double fraction.
- R8: An immediate with exponent 255 and zero fraction yields a double infinity `{sign, 11'h7FF, 52'b0}`.
- R9: An immediate with exponent 255 and a non-zero fraction yields `{sign, 11'h7FF, fraction, 29'b0}`, so the payload and the quiet bit (double fraction bit 51) are kept.
- R10: `instrWord[0]` is always an immediate bit and never a flag. A word with bit 0 set is accepted like any other matching word, and that bit sets the sign of the result.
- R11: While `rstN` is low and right after reset, `resValid`, `resData` and `resDest` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word strobe |
| instrWord | input | 32 | Instruction word carrying opcodes, destination and immediate |
| resValid | output | 1 | Result strobe, one cycle after an accepted word |
| resData | output | 64 | Double-precision result |
| resDest | output | 5 | Destination register index |

## Verification
The widener is tried with immediates from each class: positive and negative zero, the largest and smallest normals, the smallest and largest subnormals, both infinities, and quiet and signalling NaNs. These separate the rebias path, the renormalising shift and the all-ones exponent path. Words that differ from the expected opcodes only in the major or only in the extended field, matching words with the strobe low, and back-to-back matching words test decode and hold behaviour apart from the arithmetic. A sweep of patterned immediates with bit 0 set and clear checks that field reassembly does not confuse the lone top bit with the 15-bit field.

// File: rtl/bfx_pkg.sv
`timescale 1ns/1ps
package bfx_pkg;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int IMM_W      = 16;
  localparam int REG_W      = 5;
  localparam int LZ_W       = $clog2(SGL_FRAC_W + 1);
  localparam int BIAS_DIFF  = (2 ** (DBL_EXP_W - 1) - 1) - (2 ** (SGL_EXP_W - 1) - 1);
  localparam int PAD_W      = DBL_FRAC_W - SGL_FRAC_W;

  typedef struct packed {
    logic capture;
    logic validSet;
  } ctrlStrobes_t;

  function automatic logic [LZ_W-1:0] countLead(input logic [SGL_FRAC_W-1:0] f);
    logic [LZ_W-1:0] n;
    logic seen;
    n = '0;
    seen = 1'b0;
    for (int i = SGL_FRAC_W - 1; i >= 0; i--) begin
      if (f[i]) seen = 1'b1;
      else if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/bfx_ctrl.sv
`timescale 1ns/1ps
module bfx_ctrl
  import bfx_pkg::*;
#(
  parameter logic [5:0] MAJOR_OP = 6'd19,
  parameter logic [4:0] EXT_OP   = 5'd22
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrValid,
  input  logic [31:0]  instrWord,
  output ctrlStrobes_t strobes,
  output logic         resValid
);
  logic majorHit;
  logic extHit;

  always_comb begin
    majorHit = (instrWord[31:26] == MAJOR_OP);
    extHit   = (instrWord[5:1] == EXT_OP);
    strobes.validSet = instrValid && majorHit && extHit;
    strobes.capture  = strobes.validSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= strobes.validSet;
  end
endmodule

// File: rtl/bfx_datapath.sv
`timescale 1ns/1ps
module bfx_datapath
  import bfx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [31:0]         instrWord,
  input  ctrlStrobes_t        strobes,
  output logic [63:0]         resData,
  output logic [REG_W-1:0]    resDest
);
  logic [IMM_W-1:0]      immBits;
  logic [31:0]           single;
  logic                  sgn;
  logic [SGL_EXP_W-1:0]  sExp;
  logic [SGL_FRAC_W-1:0] sFrac;
  logic [LZ_W-1:0]       leadZeros;
  logic [SGL_FRAC_W-1:0] shifted;
  logic [SGL_FRAC_W-1:0] subFrac;
  logic [DBL_EXP_W-1:0]  dExp;
  logic [SGL_FRAC_W-1:0] dTop;
  logic [63:0]           dblNext;

  always_comb begin
    immBits = {instrWord[0], instrWord[20:6]};
    single  = {immBits, {(32 - IMM_W){1'b0}}};
    sgn     = single[31];
    sExp    = single[30:SGL_FRAC_W];
    sFrac   = single[SGL_FRAC_W-1:0];

    leadZeros = countLead(sFrac);
    shifted   = sFrac << leadZeros;
    subFrac   = {shifted[SGL_FRAC_W-2:0], 1'b0};

    if (sExp == '0 && sFrac == '0) begin
      dExp = '0;
      dTop = '0;
    end else if (sExp == '0) begin
      dExp = DBL_EXP_W'(BIAS_DIFF) - DBL_EXP_W'(leadZeros);
      dTop = subFrac;
    end else if (sExp == '1) begin
      dExp = '1;
      dTop = sFrac;
    end else begin
      dExp = DBL_EXP_W'(sExp) + DBL_EXP_W'(BIAS_DIFF);
      dTop = sFrac;
    end
    dblNext = {sgn, dExp, dTop, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      resDest <= '0;
    end else if (strobes.capture) begin
      resData <= dblNext;
      resDest <= instrWord[25:21];
    end
  end
endmodule

// File: rtl/bf16_imm_expander.sv
`timescale 1ns/1ps
module bf16_imm_expander
  import bfx_pkg::*;
#(
  parameter logic [5:0] MAJOR_OP = 6'd19,
  parameter logic [4:0] EXT_OP   = 5'd22
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [31:0] instrWord,
  output logic        resValid,
  output logic [63:0] resData,
  output logic [4:0]  resDest
);
  ctrlStrobes_t strobes;

  bfx_ctrl #(.MAJOR_OP(MAJOR_OP), .EXT_OP(EXT_OP)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .instrValid(instrValid),
    .instrWord (instrWord),
    .strobes   (strobes),
    .resValid  (resValid)
  );

  bfx_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .instrWord(instrWord),
    .strobes  (strobes),
    .resData  (resData),
    .resDest  (resDest)
  );
endmodule

// File: rtl/bfx_checker.sv
`timescale 1ns/1ps
module bfx_checker #(
  parameter logic [5:0] MAJOR_OP = 6'd19,
  parameter logic [4:0] EXT_OP   = 5'd22
) (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [31:0] instrWord,
  input logic        resValid,
  input logic [63:0] resData,
  input logic [4:0]  resDest
);
  logic hit;
  assign hit = instrValid && (instrWord[31:26] == MAJOR_OP) && (instrWord[5:1] == EXT_OP);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN) hit |=> resValid);
  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN) !hit |=> !resValid);
  // R3
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> ($stable(resData) && $stable(resDest)));
  // R4
  dest_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (resDest == $past(instrWord[25:21])));
  // R10
  sign_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (resData[63] == $past(instrWord[0])));
  // R5
  zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && instrWord[20:6] == 15'd0) |=> (resData[62:0] == 63'd0));
  // R8
  allones_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && instrWord[20:13] == 8'hFF) |=> (resData[62:52] == 11'h7FF));
  // R11
  reset_chk: assert property (@(posedge clk) !rstN |=> (!resValid && resData == 64'd0 && resDest == 5'd0));
endmodule

bind bf16_imm_expander bfx_checker #(.MAJOR_OP(MAJOR_OP), .EXT_OP(EXT_OP)) chk_i (.*);

// File: tb/bf16_imm_expander_tb.sv
`timescale 1ns/1ps
module bf16_imm_expander_tb_top;
  typedef struct {
    logic [63:0] data;
    logic [4:0]  dest;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        resValid;
  logic [63:0] resData;
  logic [4:0]  resDest;

  int checks = 0;
  int errors = 0;
  logic expectNow = 1'b0;
  logic monitorOn = 1'b0;
  logic [63:0] lastData = '0;
  logic [4:0]  lastDest = '0;
  expItem_t scoreQ[$];
  int cycles = 0;

  always #2 clk = ~clk;

  bf16_imm_expander dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .resValid(resValid), .resData(resData), .resDest(resDest)
  );

  function automatic logic [63:0] refExpand(input logic [15:0] b);
    logic s;
    logic [7:0] e;
    logic [22:0] f;
    int ex;
    s = b[15];
    e = b[14:7];
    f = {b[6:0], 16'h0};
    if (e == 8'd0 && f == 23'd0) return {s, 63'd0};
    if (e == 8'hFF) return {s, 11'h7FF, f, 29'd0};
    if (e == 8'd0) begin
      ex = -126;
      while (!f[22]) begin
        f = f << 1;
        ex = ex - 1;
      end
      f = f << 1;
      ex = ex - 1;
    end else begin
      ex = int'(e) - 127;
    end
    return {s, 11'(ex + 1023), f, 29'd0};
  endfunction

  function automatic logic [31:0] mkWord(input logic [5:0] major, input logic [4:0] dest,
                                         input logic [15:0] imm, input logic [4:0] ext);
    return {major, dest, imm[14:0], ext, imm[15]};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w, input logic v, input string tag);
    expItem_t it;
    @(negedge clk);
    instrValid = v;
    instrWord  = w;
    expectNow  = v && (w[31:26] == 6'd19) && (w[5:1] == 5'd22);
    if (expectNow) begin
      it.data = refExpand({w[0], w[20:6]});
      it.dest = w[25:21];
      it.tag  = tag;
      scoreQ.push_back(it);
    end
  endtask

  task automatic sendImm(input logic [15:0] imm, input logic [4:0] dest, input string tag);
    sendWord(mkWord(6'd19, dest, imm, 5'd22), 1'b1, tag);
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (monitorOn) begin
        if (expectNow) begin
          check(resValid === 1'b1, "R2 valid", {63'd0, resValid}, 64'd1);
          if (resValid === 1'b1 && scoreQ.size() > 0) begin
            it = scoreQ.pop_front();
            check(resData === it.data, it.tag, resData, it.data);
            check(resDest === it.dest, "R4 dest", {59'd0, resDest}, {59'd0, it.dest});
            lastData = it.data;
            lastDest = it.dest;
          end
        end else begin
          check(resValid === 1'b0, "R3 no valid", {63'd0, resValid}, 64'd0);
          check(resData === lastData, "R3 hold data", resData, lastData);
          check(resDest === lastDest, "R3 hold dest", {59'd0, resDest}, {59'd0, lastDest});
        end
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R11: reset state
    check(resValid === 1'b0, "R11 valid", {63'd0, resValid}, 64'd0);
    check(resData === 64'd0, "R11 data", resData, 64'd0);
    check(resDest === 5'd0, "R11 dest", {59'd0, resDest}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    monitorOn = 1'b1;

    // R5 signed zeros
    sendImm(16'h0000, 5'd1, "R5 +zero");
    sendImm(16'h8000, 5'd2, "R5 -zero R10");
    // R6 normals
    sendImm(16'h3F80, 5'd3, "R6 one");
    sendImm(16'hC020, 5'd4, "R6 -2.5 R10");
    sendImm(16'h7F7F, 5'd5, "R6 max normal");
    sendImm(16'h0080, 5'd6, "R6 min normal");
    // R7 subnormals
    sendImm(16'h0001, 5'd7, "R7 smallest subnormal");
    sendImm(16'h0040, 5'd8, "R7 top subnormal");
    sendImm(16'h807F, 5'd9, "R7 neg subnormal");
    sendImm(16'h0015, 5'd10, "R7 mid subnormal");
    // R8 infinities
    sendImm(16'h7F80, 5'd11, "R8 +inf");
    sendImm(16'hFF80, 5'd12, "R8 -inf");
    // R9 NaNs
    sendImm(16'h7FC0, 5'd13, "R9 quiet nan");
    sendImm(16'h7F81, 5'd14, "R9 signalling nan");
    sendImm(16'hFFD5, 5'd15, "R9 neg nan payload");

    // R3 rejected words
    sendWord(mkWord(6'd18, 5'd20, 16'h4000, 5'd22), 1'b1, "R3 bad major");
    sendWord(mkWord(6'd19, 5'd21, 16'h4000, 5'd23), 1'b1, "R3 bad ext");
    sendWord(mkWord(6'd19, 5'd22, 16'h4000, 5'd22), 1'b0, "R3 strobe low");
    sendWord(mkWord(6'd19, 5'd23, 16'h4000, 5'd22), 1'b1, "R2 accept after idle");
    sendWord(32'hFFFF_FFFF, 1'b1, "R3 all ones");

    // R1 R10 patterned sweep, back to back
    for (int i = 0; i < 64; i++) begin
      logic [15:0] imm;
      imm = 16'(i * 16'h0403) ^ 16'(i << 9) ^ ((i % 2 == 1) ? 16'h8000 : 16'h0000);
      sendImm(imm, 5'(i), "R1 sweep");
    end

    sendWord(32'd0, 1'b0, "idle");
    sendWord(32'd0, 1'b0, "idle");
    @(negedge clk);
    check(scoreQ.size() == 0, "R2 queue drained", 64'(scoreQ.size()), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule